// File: doc/BRIEF.md
# Request/Grant Bus Exchange Controller

This block decides who owns a shared local bus. Each neighbouring master is reached over one open-drain line on which a pulse is a single low clock. A master further down the chain asks for the bus on the secondary port. If this block holds the bus at that moment, it waits for a bus-cycle boundary and answers with a grant pulse. It then floats its bus drivers and stays in an acknowledge state until the requester sends a release pulse. If this block does not hold the bus, it relays the whole three-pulse sequence to the upstream port. The request and release are each delayed by one clock and the grant by two.

Each port is an open-drain wire. The block reads the sampled level and drives an enable that pulls the wire low. A high level always means "no pulse". Because the block also reads back its own pulses, a low level it is driving itself is never taken for an incoming pulse. Exactly one quiet clock must follow every exchange. Any pulse that arrives out of order, or in that quiet clock, is ignored and latches a protocol-error flag.

Reset enters on an active-low pin. It is synchronised inside the block and acts only after it has been held for at least four clocks.

Top module: `bus_xchg_ctrl`

## Requirements
- R1: After `rst_n` has been held low for at least four clocks, `sec_pull_o`, `up_pull_o`, `bus_float_o`, `ack_o` and `proto_err_o` are all 0, and they stay 0 until a new exchange starts.
- R2: A low pulse on `rst_n` that lasts fewer than four clocks has no effect: an exchange in progress keeps its float and acknowledge outputs.
- R3: In owner mode (`bus_owner_i`=1), a request sampled on the secondary line is answered by a one-clock grant on `sec_pull_o`. The grant appears in the clock after the first later sample in which `bus_tstate_i` is T4 (2'd3) or T1 (2'd0), and never after a sample of T2 (2'd1) or T3 (2'd2).
- R4: `bus_float_o` rises in the same clock as the owner-mode grant. `ack_o` rises one clock later. Both stay high until a release pulse.
- R5: A release pulse sampled on the secondary line during acknowledge clears `bus_float_o` and `ack_o` in the next clock.
- R6: In pass-through mode (`bus_owner_i`=0), a request sampled on the secondary line appears as a one-clock pulse on `up_pull_o` one clock later. `bus_float_o` and `ack_o` stay 0.
- R7: In pass-through mode, a grant sampled on the upstream line appears on `sec_pull_o` two clocks later.
- R8: In pass-through mode, a release sampled on the secondary line appears on `up_pull_o` one clock later.
- R9: The first sample after a release is a dead cycle. A pulse seen there is not acted on and sets `proto_err_o`. A request sampled one clock after the dead cycle is accepted.
- R10: A pulse that is out of order is ignored and sets `proto_err_o`, for example a second request while waiting for a grant. The flag stays set until a reset of at least four clocks.
- R11: A high line level never counts as a pulse, and the block's own pull-low is never read back as an incoming pulse: a grant is not mistaken for a release.
- R12: Every pulse on `sec_pull_o` or `up_pull_o` is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronised inside, must last at least four clocks |
| bus_owner_i | input | 1 | 1 when this block currently holds the local bus |
| bus_tstate_i | input | 2 | Current bus state: T1=0, T2=1, T3=2, T4=3 |
| sec_line_i | input | 1 | Sampled level of the secondary (downstream) request/grant line |
| sec_pull_o | output | 1 | Pull-low enable for the secondary line |
| up_line_i | input | 1 | Sampled level of the upstream request/grant line |
| up_pull_o | output | 1 | Pull-low enable for the upstream line |
| bus_float_o | output | 1 | Bus drivers must be tri-stated |
| ack_o | output | 1 | Acknowledge state: bus lent out, control logic detached |
| proto_err_o | output | 1 | Sticky flag for an ignored out-of-order or dead-cycle pulse |

## Verification
The bench holds the bus in T2 and T3 after a request. A design that granted at once, or on any state other than T4 or T1, would send the grant early. It keeps the owner-mode exchange idle for several clocks after the grant. A design that read its own grant back as a release would drop the float right after granting. It pulses reset for only two clocks mid-exchange, which a design without the length filter would turn into an aborted exchange. It places a pulse in the dead cycle and a second request in the grant wait. A design that acted on either of these would forward an extra pulse, which the scoreboard catches as unexpected. A design that got the 1/2/1 relay delays off by one clock would show each relayed pulse in the wrong cycle.

// File: rtl/bus_xchg_pkg.sv
// Package: shared types and constants for the request/grant exchange block.
// Assumes a two-bit bus state code in which T1..T4 map to 0..3.
package bus_xchg_pkg;

    localparam int TS_W      = 2;
    localparam int NPORTS    = 2;
    localparam int PORT_SEC  = 0;
    localparam int PORT_UP   = 1;

    typedef enum logic [TS_W-1:0] {
        TS_T1 = 2'd0,
        TS_T2 = 2'd1,
        TS_T3 = 2'd2,
        TS_T4 = 2'd3
    } tstate_e;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_O_WAIT  = 4'd1,
        ST_O_GRANT = 4'd2,
        ST_O_ACK   = 4'd3,
        ST_P_WAITG = 4'd4,
        ST_P_G1    = 4'd5,
        ST_P_G2    = 4'd6,
        ST_P_ACK   = 4'd7,
        ST_DEAD    = 4'd8
    } xchg_state_e;

    // True for the bus states in which the bus may be handed over.
    function automatic logic is_boundary(input logic [TS_W-1:0] ts);
        return (ts == TS_T4) || (ts == TS_T1);
    endfunction

endpackage

// File: rtl/bus_xchg_rst_filter.sv
// Reset filter: synchronises the external active-low reset and asserts the
// internal reset only after MIN_CYC consecutive synchronised low samples.
// Assumes SYNC_STAGES >= 2. Deassertion follows the synchroniser directly.
module bus_xchg_rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYC     = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_int_n
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   rst_q;
    logic                   sync_low;

    assign sync_low  = ~sync_q[SYNC_STAGES-1];
    assign rst_int_n = rst_q;

    // Purpose: move the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], rst_n};
    end

    // Purpose: count consecutive low samples, saturating at MIN_CYC.
    always_ff @(posedge clk) begin
        if (!sync_low) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_W'(MIN_CYC)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Purpose: assert internal reset on the MIN_CYC-th low sample.
    always_ff @(posedge clk) begin
        rst_q <= !(sync_low && (cnt_q >= CNT_W'(MIN_CYC - 1)));
    end

endmodule

// File: rtl/bus_xchg_pulse_det.sv
// Pulse detector: turns sampled open-drain levels into pulse strobes.
// A low level counts only when this block is not pulling that line itself.
module bus_xchg_pulse_det #(
    parameter int N = 2
) (
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] pull_i,
    output logic [N-1:0] pulse_o
);
    for (genvar g = 0; g < N; g++) begin : g_port
        // Purpose: mask this block's own drive on port g.
        always_comb begin
            pulse_o[g] = ~line_i[g] & ~pull_i[g];
        end
    end

endmodule

// File: rtl/bus_xchg_fsm.sv
// Exchange sequencer: runs the request/grant/release sequence in owner
// mode or relays it in pass-through mode, then enforces one dead cycle.
// Assumes pulse strobes already exclude this block's own pulls.
// All outputs are registered.
module bus_xchg_fsm
    import bus_xchg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_owner_i,
    input  logic [TS_W-1:0] bus_tstate_i,
    input  logic            sec_pulse_i,
    input  logic            up_pulse_i,
    output logic            sec_pull_o,
    output logic            up_pull_o,
    output logic            float_o,
    output logic            ack_o,
    output logic            err_o
);
    xchg_state_e state_q, state_d;
    logic sec_pull_q, sec_pull_d;
    logic up_pull_q, up_pull_d;
    logic float_q, float_d;
    logic ack_q, ack_d;
    logic err_q, viol;

    assign sec_pull_o = sec_pull_q;
    assign up_pull_o  = up_pull_q;
    assign float_o    = float_q;
    assign ack_o      = ack_q;
    assign err_o      = err_q;

    // Purpose: next state, next outputs and protocol violation detection.
    always_comb begin
        state_d    = state_q;
        sec_pull_d = 1'b0;
        up_pull_d  = 1'b0;
        float_d    = float_q;
        ack_d      = ack_q;
        viol       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                float_d = 1'b0;
                ack_d   = 1'b0;
                if (sec_pulse_i) begin
                    if (bus_owner_i) begin
                        state_d = ST_O_WAIT;
                    end else begin
                        state_d   = ST_P_WAITG;
                        up_pull_d = 1'b1;
                    end
                end else if (up_pulse_i) begin
                    viol = 1'b1;
                end
            end
            ST_O_WAIT: begin
                viol = sec_pulse_i | up_pulse_i;
                if (is_boundary(bus_tstate_i)) begin
                    state_d    = ST_O_GRANT;
                    sec_pull_d = 1'b1;
                    float_d    = 1'b1;
                end
            end
            ST_O_GRANT: begin
                viol    = up_pulse_i;
                state_d = ST_O_ACK;
                ack_d   = 1'b1;
            end
            ST_O_ACK: begin
                viol = up_pulse_i;
                if (sec_pulse_i) begin
                    state_d = ST_DEAD;
                    float_d = 1'b0;
                    ack_d   = 1'b0;
                end
            end
            ST_P_WAITG: begin
                viol = sec_pulse_i;
                if (up_pulse_i) begin
                    state_d = ST_P_G1;
                end
            end
            ST_P_G1: begin
                viol       = sec_pulse_i | up_pulse_i;
                state_d    = ST_P_G2;
                sec_pull_d = 1'b1;
            end
            ST_P_G2: begin
                viol    = up_pulse_i;
                state_d = ST_P_ACK;
            end
            ST_P_ACK: begin
                viol = up_pulse_i;
                if (sec_pulse_i) begin
                    state_d   = ST_DEAD;
                    up_pull_d = 1'b1;
                end
            end
            ST_DEAD: begin
                viol    = sec_pulse_i | up_pulse_i;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Purpose: state and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sec_pull_q <= 1'b0;
            up_pull_q  <= 1'b0;
            float_q    <= 1'b0;
            ack_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            sec_pull_q <= sec_pull_d;
            up_pull_q  <= up_pull_d;
            float_q    <= float_d;
            ack_q      <= ack_d;
            err_q      <= err_q | viol;
        end
    end

endmodule

// File: rtl/bus_xchg_ctrl.sv
// Top: local-bus ownership control over two open-drain request/grant lines.
// Assumes the line inputs are already sampled levels and that the pull
// outputs drive open-drain pads that bring those lines low.
module bus_xchg_ctrl
    import bus_xchg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_MIN_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_owner_i,
    input  logic [TS_W-1:0] bus_tstate_i,
    input  logic            sec_line_i,
    output logic            sec_pull_o,
    input  logic            up_line_i,
    output logic            up_pull_o,
    output logic            bus_float_o,
    output logic            ack_o,
    output logic            proto_err_o
);
    logic              rst_int_n;
    logic [NPORTS-1:0] line_vec;
    logic [NPORTS-1:0] pull_vec;
    logic [NPORTS-1:0] pulse_vec;

    // Purpose: gather the port lines and own pulls into vectors.
    always_comb begin
        line_vec           = '1;
        pull_vec           = '0;
        line_vec[PORT_SEC] = sec_line_i;
        line_vec[PORT_UP]  = up_line_i;
        pull_vec[PORT_SEC] = sec_pull_o;
        pull_vec[PORT_UP]  = up_pull_o;
    end

    bus_xchg_rst_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_CYC     (RST_MIN_CYC)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_int_n (rst_int_n)
    );

    bus_xchg_pulse_det #(
        .N (NPORTS)
    ) u_det (
        .line_i  (line_vec),
        .pull_i  (pull_vec),
        .pulse_o (pulse_vec)
    );

    bus_xchg_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_int_n),
        .bus_owner_i  (bus_owner_i),
        .bus_tstate_i (bus_tstate_i),
        .sec_pulse_i  (pulse_vec[PORT_SEC]),
        .up_pulse_i   (pulse_vec[PORT_UP]),
        .sec_pull_o   (sec_pull_o),
        .up_pull_o    (up_pull_o),
        .float_o      (bus_float_o),
        .ack_o        (ack_o),
        .err_o        (proto_err_o)
    );

endmodule

// File: rtl/bus_xchg_ctrl_chk.sv
// Checker: temporal properties of the exchange outputs. It is bound into
// the top module and uses the filtered internal reset for disabling.
module bus_xchg_ctrl_chk
    import bus_xchg_pkg::*;
(
    input logic            clk,
    input logic            rst_int_n,
    input logic [TS_W-1:0] bus_tstate_i,
    input logic            sec_pull_o,
    input logic            up_pull_o,
    input logic            bus_float_o,
    input logic            ack_o,
    input logic            proto_err_o
);
    AST_SEC_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_int_n)
        sec_pull_o |=> !sec_pull_o); // R12
    AST_UP_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_int_n)
        up_pull_o |=> !up_pull_o); // R12
    AST_GRANT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_int_n)
        $rose(bus_float_o) |-> sec_pull_o && ($past(bus_tstate_i) == TS_T4 || $past(bus_tstate_i) == TS_T1)); // R3
    AST_ACK_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_int_n)
        $rose(bus_float_o) |=> ack_o); // R4
    AST_ACK_IMPLIES_FLOAT: assert property (@(posedge clk) disable iff (!rst_int_n)
        ack_o |-> bus_float_o); // R4
    AST_RELEASE_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_int_n)
        $fell(ack_o) |-> !bus_float_o); // R5
    AST_PASS_NO_FLOAT: assert property (@(posedge clk) disable iff (!rst_int_n)
        up_pull_o |-> !bus_float_o); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_int_n)
        proto_err_o |=> proto_err_o); // R10
endmodule

bind bus_xchg_ctrl bus_xchg_ctrl_chk u_chk (
    .clk          (clk),
    .rst_int_n    (rst_int_n),
    .bus_tstate_i (bus_tstate_i),
    .sec_pull_o   (sec_pull_o),
    .up_pull_o    (up_pull_o),
    .bus_float_o  (bus_float_o),
    .ack_o        (ack_o),
    .proto_err_o  (proto_err_o)
);

// File: tb/test_bus_xchg_ctrl.sv
// Scoreboard bench: the driver queues the expected pull pulses and the
// monitor matches each observed pulse to the head of that queue.
module test_bus_xchg_ctrl;
    import bus_xchg_pkg::*;

    typedef struct {
        int    cyc;
        int    port;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       owner = 1'b0;
    logic [1:0] tstate = TS_T2;
    logic       sec_drv = 1'b0;
    logic       up_drv = 1'b0;
    logic       sec_line, up_line;
    logic       sec_pull, up_pull, bus_float, ack, perr;
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    exp_t       exq[$];
    logic [1:0] prev_pull = 2'b00;

    assign sec_line = ~(sec_drv | sec_pull);
    assign up_line  = ~(up_drv | up_pull);

    bus_xchg_ctrl i_bus_xchg_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_owner_i  (owner),
        .bus_tstate_i (tstate),
        .sec_line_i   (sec_line),
        .sec_pull_o   (sec_pull),
        .up_line_i    (up_line),
        .up_pull_o    (up_pull),
        .bus_float_o  (bus_float),
        .ack_o        (ack),
        .proto_err_o  (perr)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic expect_pulse(input int port, input int dly, input string req);
        exq.push_back('{cyc: cyc + dly, port: port, req: req});
    endtask

    task automatic tick(input logic s, input logic u, input logic [1:0] ts);
        sec_drv = s;
        up_drv  = u;
        tstate  = ts;
        @(posedge clk);
        @(negedge clk);
        sec_drv = 1'b0;
        up_drv  = 1'b0;
    endtask

    task automatic hold_reset(input int n);
        rst_n = 1'b0;
        repeat (n) tick(1'b0, 1'b0, TS_T2);
        rst_n = 1'b1;
        repeat (4) tick(1'b0, 1'b0, TS_T2);
    endtask

    // Monitor: match each observed pull pulse with the scoreboard head.
    always @(negedge clk) begin
        logic [1:0] now_pull;
        now_pull = {up_pull, sec_pull};
        while (exq.size() > 0 && exq[0].cyc < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s: actual no pulse on port %0d expected pulse in cycle %0d",
                     exq[0].req, exq[0].port, exq[0].cyc);
            void'(exq.pop_front());
        end
        for (int p = 0; p < 2; p++) begin
            if (now_pull[p]) begin
                checks++;
                if (prev_pull[p]) begin
                    errors++;
                    $display("FAIL R12: actual pulse on port %0d wider than 1 clock expected 1 clock", p);
                end else if (exq.size() > 0 && exq[0].cyc == cyc && exq[0].port == p) begin
                    void'(exq.pop_front());
                end else begin
                    errors++;
                    $display("FAIL R11 R12: actual unexpected pulse port %0d cycle %0d expected none", p, cyc);
                end
            end
        end
        prev_pull = now_pull;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: long reset
        rst_n = 1'b0;
        repeat (8) tick(1'b0, 1'b0, TS_T2);
        chk(sec_pull, 1'b0, "R1 sec_pull in reset");
        chk(bus_float, 1'b0, "R1 float in reset");
        rst_n = 1'b1;
        repeat (5) tick(1'b0, 1'b0, TS_T2);
        chk(up_pull, 1'b0, "R1 up_pull after reset");
        chk(ack, 1'b0, "R1 ack after reset");
        chk(perr, 1'b0, "R1 err after reset");

        // Owner mode: grant held off through T2/T3
        owner = 1'b1;
        tick(1'b1, 1'b0, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        chk(bus_float, 1'b0, "R3 no grant after T2");
        tick(1'b0, 1'b0, TS_T3);
        chk(bus_float, 1'b0, "R3 no grant after T3");
        expect_pulse(PORT_SEC, 1, "R3");
        tick(1'b0, 1'b0, TS_T4);
        chk(bus_float, 1'b1, "R4 float with grant");
        chk(ack, 1'b0, "R4 ack not yet");
        tick(1'b0, 1'b0, TS_T1);
        chk(ack, 1'b1, "R4 ack one clock later");
        chk(bus_float, 1'b1, "R4 float held");
        tick(1'b0, 1'b0, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        chk(ack, 1'b1, "R11 own grant not a release");

        // R2: short reset mid-exchange
        rst_n = 1'b0;
        repeat (2) tick(1'b0, 1'b0, TS_T2);
        rst_n = 1'b1;
        repeat (4) tick(1'b0, 1'b0, TS_T2);
        chk(ack, 1'b1, "R2 ack survives short reset");
        chk(bus_float, 1'b1, "R2 float survives short reset");

        tick(1'b1, 1'b0, TS_T2);
        chk(bus_float, 1'b0, "R5 float cleared by release");
        chk(ack, 1'b0, "R5 ack cleared by release");
        tick(1'b0, 1'b0, TS_T2);
        chk(perr, 1'b0, "R9 clean dead cycle");

        // Owner mode: immediate boundary T1
        tick(1'b1, 1'b0, TS_T2);
        expect_pulse(PORT_SEC, 1, "R3 T1");
        tick(1'b0, 1'b0, TS_T1);
        chk(bus_float, 1'b1, "R3 grant at T1");
        tick(1'b0, 1'b0, TS_T3);
        tick(1'b1, 1'b0, TS_T3);
        chk(bus_float, 1'b0, "R5 release");
        tick(1'b0, 1'b0, TS_T3);

        // Pass-through mode
        owner = 1'b0;
        expect_pulse(PORT_UP, 1, "R6");
        tick(1'b1, 1'b0, TS_T2);
        chk(bus_float, 1'b0, "R6 no float in pass-through");
        chk(ack, 1'b0, "R6 no ack in pass-through");
        tick(1'b0, 1'b0, TS_T2);
        expect_pulse(PORT_SEC, 2, "R7");
        tick(1'b0, 1'b1, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        expect_pulse(PORT_UP, 1, "R8");
        tick(1'b1, 1'b0, TS_T2);
        chk(perr, 1'b0, "R8 no error on in-order sequence");

        // R9: pulse in dead cycle is ignored and flagged
        tick(1'b1, 1'b0, TS_T2);
        chk(perr, 1'b1, "R9 dead-cycle pulse flagged");
        tick(1'b0, 1'b0, TS_T2);
        expect_pulse(PORT_UP, 1, "R9 accepted after dead cycle");
        tick(1'b1, 1'b0, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        expect_pulse(PORT_SEC, 2, "R7");
        tick(1'b0, 1'b1, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        expect_pulse(PORT_UP, 1, "R8");
        tick(1'b1, 1'b0, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        chk(perr, 1'b1, "R10 error sticky");

        // Reset clears the flag
        hold_reset(6);
        chk(perr, 1'b0, "R1 reset clears error");

        // R10: second request while waiting for grant
        expect_pulse(PORT_UP, 1, "R6");
        tick(1'b1, 1'b0, TS_T2);
        tick(1'b1, 1'b0, TS_T2);
        chk(perr, 1'b1, "R10 out-of-order request flagged");
        expect_pulse(PORT_SEC, 2, "R7");
        tick(1'b0, 1'b1, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        tick(1'b0, 1'b0, TS_T2);
        expect_pulse(PORT_UP, 1, "R8");
        tick(1'b1, 1'b0, TS_T2);
        repeat (6) tick(1'b0, 1'b0, TS_T4);
        chk(perr, 1'b1, "R10 still sticky");
        chk(sec_pull, 1'b0, "R11 idle high lines");
        chk(up_pull, 1'b0, "R11 idle high lines");

        checks++;
        if (exq.size() != 0) begin
            errors++;
            $display("FAIL R6 R7 R8: actual %0d pending expected 0", exq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule